// File: doc/BRIEF.md
# Polynomial Modular Accumulate Unit

This unit folds a stream of product coefficients into a 256-coefficient result polynomial held in a synchronous RAM, reducing every sum modulo the prime Q. It forms one row of a matrix-vector result: t[i] = e[i] + sum over columns j of A[i][j]·s[j]. A multiplier outside the unit delivers one column's product polynomial per pass, in coefficient order, with arbitrary idle cycles between coefficients.

On the first column (j = 0) the addend comes from a separate memory holding the initial polynomials, read at slot K + i. On later columns it comes from the result memory at slot i, which is overwritten in place. Both memories have a registered read port with one cycle of latency. The unit presents a read address one step ahead of the coefficient being written, so that it always fetches the old value before that location is written. It delays the source select by one cycle so that it lines up with the returned data.

A `start` pulse opens each column pass. `last_col` marks the final column of a row, and `done` pulses once that column's last coefficient has been written.

Top module: `poly_mod_acc`

## Requirements
- R1: After reset, `done` is low.
- R2: Each written value is (addend + product) mod Q, with Q = 3329. Both inputs are below Q, and Q is subtracted once when their 13-bit sum is at least Q. A sum of exactly Q writes 0, and a sum of 2Q-2 writes Q-2.
- R3: When `col_j` is 0, the addend is the initial-memory word at address (K+i)·256 + n, where n is the coefficient index and K is the run-time `k_num` (2, 3 or 4).
- R4: When `col_j` is non-zero, the addend is the result-memory word at address i·256 + n.
- R5: In the `start` cycle the coefficient part of the read address is 0. After that it is n+1 in a cycle where `prod_valid` is high and n otherwise. The slot part of the read address is as given in R3 and R4.
- R6: A cycle with `prod_valid` high writes the result to address i·256 + n (`t_we` high) and then advances n by one. A `start` pulse resets n to 0.
- R7: Idle cycles between valid products change neither the written values nor their addresses.
- R8: `done` is high for exactly the one cycle that follows the write of index 255 in a pass with `last_col` high, and it stays low at the end of other passes.
- R9: After all K columns of row i have been applied, result slot i holds e[K+i] + the sum over j of the products, mod Q, for every coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a column pass: index to 0 |
| k_num | input | 3 | Vector length K (2..4) |
| row_i | input | 2 | Row index i |
| col_j | input | 2 | Column index j of this pass |
| last_col | input | 1 | This pass is the row's final column |
| prod_valid | input | 1 | Product coefficient valid this cycle |
| prod_coeff | input | 12 | Product coefficient, below Q |
| e_rd_addr | output | 11 | Initial-polynomial memory read address |
| e_rd_data | input | 12 | Initial memory registered read data |
| t_rd_addr | output | 10 | Result memory read address |
| t_rd_data | input | 12 | Result memory registered read data |
| t_we | output | 1 | Result memory write enable |
| t_wa | output | 10 | Result memory write address |
| t_wd | output | 12 | Result memory write data |
| done | output | 1 | One-cycle pulse at the end of the last column |

## Verification
In any back-to-back stretch of valid products, the read of coefficient n+1 and the write of coefficient n fall in the same cycle on the same result memory. A wrong read-ahead would therefore return a value that has just been overwritten, or one from a stale location. The bench provokes this with unbroken product bursts, with random gaps of up to three cycles, and with a gap at every coefficient. It checks the read address in each cycle against its own count of n. It then compares the whole result polynomial with a software sum mod Q, which includes coefficients chosen to hit the Q and 2Q-2 boundaries.

// File: rtl/poly_mod_acc.sv
module poly_mod_acc #(
  parameter int CW     = 12,
  parameter int LOG_N  = 8,
  parameter int Q      = 3329,
  parameter int SLOT_W = 3,
  parameter int ROW_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [SLOT_W-1:0]       k_num,
  input  logic [ROW_W-1:0]        row_i,
  input  logic [ROW_W-1:0]        col_j,
  input  logic                    last_col,
  input  logic                    prod_valid,
  input  logic [CW-1:0]           prod_coeff,
  output logic [SLOT_W+LOG_N-1:0] e_rd_addr,
  input  logic [CW-1:0]           e_rd_data,
  output logic [ROW_W+LOG_N-1:0]  t_rd_addr,
  input  logic [CW-1:0]           t_rd_data,
  output logic                    t_we,
  output logic [ROW_W+LOG_N-1:0]  t_wa,
  output logic [CW-1:0]           t_wd,
  output logic                    done
);
  localparam int N = 1 << LOG_N;
  localparam logic [LOG_N-1:0] LAST = LOG_N'(N - 1);
  localparam logic [CW:0] QW = (CW+1)'(Q);

  logic [LOG_N-1:0]  idx;
  logic              first_q;
  logic [LOG_N-1:0]  ra;
  logic [SLOT_W-1:0] e_slot;
  logic [CW-1:0]     addend;
  logic [CW:0]       sum;

  assign ra     = start ? '0 : (prod_valid ? idx + 1'b1 : idx);
  assign e_slot = k_num + {{(SLOT_W-ROW_W){1'b0}}, row_i};
  assign e_rd_addr = {e_slot, ra};
  assign t_rd_addr = {row_i, ra};

  assign addend = first_q ? e_rd_data : t_rd_data;
  assign sum    = {1'b0, addend} + {1'b0, prod_coeff};
  assign t_wd   = (sum >= QW) ? CW'(sum - QW) : sum[CW-1:0];
  assign t_we   = prod_valid;
  assign t_wa   = {row_i, idx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      first_q <= 1'b0;
      done    <= 1'b0;
    end else begin
      first_q <= (col_j == '0);
      done    <= prod_valid && (idx == LAST) && last_col;
      if (start) idx <= '0;
      else if (prod_valid) idx <= idx + 1'b1;
    end
  end

  // R2
  wd_below_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_we |-> (t_wd < CW'(Q)));

  // R4
  t_read_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_we && !first_q) |-> ($past(t_rd_addr) == t_wa));

  // R3
  e_read_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_we && first_q) |-> ($past(e_rd_addr[LOG_N-1:0]) == t_wa[LOG_N-1:0]));

  // R6
  write_ascends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_we && !start) |=> (start || !t_we ||
      (t_wa[LOG_N-1:0] == $past(t_wa[LOG_N-1:0]) + 1'b1)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(t_we) && $past(t_wa[LOG_N-1:0]) == LAST));
endmodule

// File: tb/tb_poly_mod_acc.sv
module tb_poly_mod_acc;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 3329;

  logic clk = 0, rst_n = 0, start = 0, last_col = 0, prod_valid = 0;
  logic [2:0] k_num = 3'd2;
  logic [1:0] row_i = 0, col_j = 0;
  logic [11:0] prod_coeff = 0;
  logic [10:0] e_rd_addr;
  logic [9:0] t_rd_addr, t_wa;
  logic [11:0] e_rd_data, t_rd_data, t_wd;
  logic t_we, done;

  logic [11:0] e_mem [0:2047];
  logic [11:0] t_mem [0:1023];
  int prod [0:3][0:255];
  int compared = 0, mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    e_rd_data <= e_mem[e_rd_addr];
    t_rd_data <= t_mem[t_rd_addr];
    if (t_we) t_mem[t_wa] <= t_wd;
  end

  poly_mod_acc dut (
    .clk(clk), .rst_n(rst_n), .start(start), .k_num(k_num), .row_i(row_i),
    .col_j(col_j), .last_col(last_col), .prod_valid(prod_valid),
    .prod_coeff(prod_coeff), .e_rd_addr(e_rd_addr), .e_rd_data(e_rd_data),
    .t_rd_addr(t_rd_addr), .t_rd_data(t_rd_data), .t_we(t_we), .t_wa(t_wa),
    .t_wd(t_wd), .done(done));

  function automatic int add_mod(int a, int b);
    int s = a + b;
    return (s >= Q) ? s - Q : s;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_row(int k, int i, int gap_mode);
    int exp_val;
    for (int n = 0; n < 256; n++) begin
      e_mem[(k+i)*256+n] = 12'($urandom % Q);
      t_mem[i*256+n] = 12'($urandom % Q);
      for (int j = 0; j < k; j++) prod[j][n] = $urandom % Q;
    end
    e_mem[(k+i)*256+0] = 12'(Q-1);
    for (int j = 0; j < k; j++) prod[j][0] = (j == 0) ? Q-1 : 0;
    e_mem[(k+i)*256+1] = 12'(Q-5);
    for (int j = 0; j < k; j++) prod[j][1] = (j == 0) ? 5 : 0;
    for (int j = 0; j < k; j++) begin
      @(negedge clk);
      start = 1; k_num = 3'(k); row_i = 2'(i); col_j = 2'(j);
      last_col = (j == k-1);
      #1;
      check(t_rd_addr == 10'(i*256), "R5", int'(t_rd_addr), i*256);
      for (int n = 0; n < 256; n++) begin
        int gap;
        gap = (gap_mode == 0) ? 0 : (gap_mode == 1) ? int'($urandom % 4) : 1;
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          start = 0; prod_valid = 0;
          #1;
          if (j == 0) check(e_rd_addr == 11'((k+i)*256+n), "R3", int'(e_rd_addr), (k+i)*256+n);
          else check(t_rd_addr == 10'(i*256+n), "R7", int'(t_rd_addr), i*256+n);
        end
        @(negedge clk);
        start = 0; prod_valid = 1; prod_coeff = 12'(prod[j][n]);
        #1;
        check(t_we && t_wa == 10'(i*256+n), "R6", int'(t_wa), i*256+n);
        if (j == 0) check(e_rd_addr == 11'((k+i)*256+((n+1)%256)), "R5", int'(e_rd_addr), (k+i)*256+((n+1)%256));
        else check(t_rd_addr == 10'(i*256+((n+1)%256)), "R5", int'(t_rd_addr), i*256+((n+1)%256));
        if (j == 0) begin
          exp_val = add_mod(int'(e_mem[(k+i)*256+n]), prod[0][n]);
          check(t_wd == 12'(exp_val), "R3", int'(t_wd), exp_val);
        end
      end
      @(negedge clk);
      prod_valid = 0;
      #1;
      check(done == (j == k-1), "R8", int'(done), int'(j == k-1));
      @(negedge clk);
      #1;
      check(done == 0, "R8", int'(done), 0);
    end
    for (int n = 0; n < 256; n++) begin
      exp_val = int'(e_mem[(k+i)*256+n]);
      for (int j = 0; j < k; j++) exp_val = add_mod(exp_val, prod[j][n]);
      check(t_mem[i*256+n] == 12'(exp_val), (n < 2) ? "R2" : (k > 1 ? "R4" : "R9"),
            int'(t_mem[i*256+n]), exp_val);
    end
    check(t_mem[i*256+0] == 12'(Q-2), "R2", int'(t_mem[i*256+0]), Q-2);
    check(t_mem[i*256+1] == 12'(0), "R2", int'(t_mem[i*256+1]), 0);
    compared++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int a = 0; a < 2048; a++) e_mem[a] = 0;
    for (int a = 0; a < 1024; a++) t_mem[a] = 0;
    repeat (3) @(negedge clk);
    #1;
    check(done == 0, "R1", int'(done), 0);
    rst_n = 1;
    run_row(2, 0, 0);
    run_row(3, 1, 1);
    run_row(4, 3, 2);
    run_row(3, 2, 1);
    run_row(2, 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule